// File: doc/BRIEF.md
# Sequential Read Output Serializer

This block produces the serial data output of a small serial memory during its two read operations. The command decoder starts it with one of two strobes. The memory-read strobe carries a word address, and the block fetches 16-bit words from the storage array through a request/valid handshake. The protect-read strobe makes the block take the 6-bit protection boundary value from its input. The block first drives a single logic-0 dummy bit. It then sends the data most significant bit first, one bit for each serial clock rising edge. The serial clock rising edge reaches the block as a one-cycle strobe in the system clock domain.

A memory read does not stop after one word. When the last bit of a word has been sent, the next bit is the first bit of the word at the next address, with no dummy bit between the two words. The address wraps from the highest location back to location 0. The block fetches each following word from the array as soon as the current word moves into the shift register, so the array has a whole word time to answer. A protect read sends its six bits and then holds the line at 0.

Chip select frames every transfer. While chip select is low the output enable is off and the block ignores every strobe. When chip select falls, the current read ends.

Top module: `serial_read_out`

## Requirements
- R1: While reset is high, `sdo_oe` and `sdo` are 0 from the next clock edge on.
- R2: A read strobe (`go_mem` or `go_prot`) seen with `cs` high gives `sdo_oe`=1 and `sdo`=0 (the dummy bit) one system clock later.
- R3: A memory word is sent most significant bit first. Each `sk_rise` strobe moves the next bit onto `sdo` one system clock after the strobe.
- R4: The bit that follows bit 0 of a word is bit 15 of the word at the next address. No dummy bit comes between the two words.
- R5: After location DEPTH-1 (15 by default), the next word read is location 0.
- R6: A protect read sends `prot_val[5]` down to `prot_val[0]` after the dummy bit, one bit per `sk_rise`.
- R7: After the sixth protect bit, further `sk_rise` strobes keep `sdo`=0 with `sdo_oe`=1.
- R8: `cs` low gives `sdo_oe`=0 one clock later and ends the read. A new read after `cs` returns high starts again with a dummy bit.
- R9: While `cs` is low, `go_mem`, `go_prot` and `sk_rise` have no effect: the output stays disabled and the block issues no array request.
- R10: The block pulses `arr_req` for one cycle with `arr_addr` when a read starts and again each time a word is loaded into the shift register. A burst that sends N words therefore issues N+1 requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, already synchronized to `clk` |
| sk_rise | input | 1 | One-cycle strobe for each serial clock rising edge |
| go_mem | input | 1 | Decoded memory read command strobe |
| go_prot | input | 1 | Decoded protect register read command strobe |
| go_addr | input | AW (4) | Start address for a memory read |
| prot_val | input | PW (6) | Current protect register contents |
| arr_req | output | 1 | Array read request pulse |
| arr_addr | output | AW (4) | Array read address |
| arr_valid | input | 1 | Array read data valid |
| arr_data | input | DW (16) | Array read data |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable; 0 means high impedance |

## Verification
The hardest case to reach is the seam between words of a burst, above all where the address wraps from location 15 to location 0. To get there the bench must send a whole word, keep chip select high and keep clocking. The stimulus starts a burst at location 14 and clocks four full words without a break, so that both a plain increment and the wrap happen in one burst. It also counts the array requests over that burst. A second burst starts at location 15 and is cut off in the middle of a word, so the bench can confirm that the next read begins with a fresh dummy bit.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    SRD_IDLE = 2'd0,
    SRD_MEM  = 2'd1,
    SRD_PROT = 2'd2
  } srd_mode_e;
endpackage

// File: rtl/srd_fetch.sv
module srd_fetch #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          take_i,
  output logic          req_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          buf_full_o,
  output logic [DW-1:0] buf_data_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic          req_q;
  logic          pend_q;
  logic          full_q;
  logic [DW-1:0] buf_q;
  logic [AW-1:0] ptr_next;

  assign ptr_next = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !cs_i) begin
      ptr_q  <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      full_q <= 1'b0;
    end else if (start_i) begin
      ptr_q  <= start_addr_i;
      req_q  <= 1'b1;
      pend_q <= 1'b1;
      full_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (take_i) begin
        ptr_q  <= ptr_next;
        req_q  <= 1'b1;
        pend_q <= 1'b1;
        full_q <= 1'b0;
      end else if (rsp_valid_i && pend_q) begin
        pend_q <= 1'b0;
        full_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_i && pend_q) buf_q <= rsp_data_i;
  end

  assign req_o      = req_q;
  assign req_addr_o = ptr_q;
  assign buf_full_o = full_q;
  assign buf_data_o = buf_q;

  // R5: the pointer wraps from the top location to zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_i && !start_i && take_i && ptr_q == LAST) |=> (req_o && req_addr_o == '0));

  // R10: a word handed to the shifter triggers the next request
  p_prefetch_r10: assert property (@(posedge clk) disable iff (rst)
    (cs_i && !start_i && take_i) |=> (req_o && !buf_full_o));
endmodule

// File: rtl/srd_shift.sv
module srd_shift
  import srd_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          mem_go_i,
  input  logic          prot_go_i,
  input  logic [PW-1:0] prot_i,
  input  logic          sk_rise_i,
  input  logic          buf_full_i,
  input  logic [DW-1:0] buf_data_i,
  output logic          take_o,
  output logic          sdo_o,
  output logic          oe_o
);
  localparam int CW = $clog2(DW + 1);

  srd_mode_e     mode_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          sdo_q;
  logic          oe_q;
  logic          step;

  assign step   = cs_i && !mem_go_i && !prot_go_i && sk_rise_i && (mode_q != SRD_IDLE);
  assign take_o = step && (mode_q == SRD_MEM) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !cs_i) begin
      mode_q <= SRD_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else if (mem_go_i) begin
      mode_q <= SRD_MEM;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else if (prot_go_i) begin
      mode_q <= SRD_PROT;
      sh_q   <= DW'(prot_i) << (DW - PW);
      cnt_q  <= CW'(PW);
      sdo_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else if (step) begin
      if (cnt_q != '0) begin
        sdo_q <= sh_q[DW-1];
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q - 1'b1;
      end else if (mode_q == SRD_MEM) begin
        sdo_q <= buf_data_i[DW-1];
        sh_q  <= buf_data_i << 1;
        cnt_q <= CW'(DW - 1);
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  // R10: a word must be buffered before the shifter needs it
  p_no_underrun_r10: assert property (@(posedge clk) disable iff (rst)
    take_o |-> buf_full_i);

  // R7: after the protect bits the line stays at 0
  p_prot_tail_r7: assert property (@(posedge clk) disable iff (rst)
    (step && mode_q == SRD_PROT && cnt_q == '0) |=> (oe_o && !sdo_o));
endmodule

// File: rtl/serial_read_out.sv
module serial_read_out #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int PW    = 6,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          sk_rise,
  input  logic          go_mem,
  input  logic          go_prot,
  input  logic [AW-1:0] go_addr,
  input  logic [PW-1:0] prot_val,
  output logic          arr_req,
  output logic [AW-1:0] arr_addr,
  input  logic          arr_valid,
  input  logic [DW-1:0] arr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  logic          mem_go;
  logic          prot_go;
  logic          take;
  logic          buf_full;
  logic [DW-1:0] buf_data;

  assign mem_go  = cs && go_mem;
  assign prot_go = cs && go_prot && !go_mem;

  srd_fetch #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .cs_i        (cs),
    .start_i     (mem_go),
    .start_addr_i(go_addr),
    .take_i      (take),
    .req_o       (arr_req),
    .req_addr_o  (arr_addr),
    .rsp_valid_i (arr_valid),
    .rsp_data_i  (arr_data),
    .buf_full_o  (buf_full),
    .buf_data_o  (buf_data)
  );

  srd_shift #(.DW(DW), .PW(PW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_i      (cs),
    .mem_go_i  (mem_go),
    .prot_go_i (prot_go),
    .prot_i    (prot_val),
    .sk_rise_i (sk_rise),
    .buf_full_i(buf_full),
    .buf_data_i(buf_data),
    .take_o    (take),
    .sdo_o     (sdo),
    .oe_o      (sdo_oe)
  );

  // R1: reset disables the output
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (!sdo_oe && !sdo));

  // R2: a read begins with a driven dummy zero
  p_dummy_r2: assert property (@(posedge clk) disable iff (rst)
    (cs && (go_mem || go_prot)) |=> (sdo_oe && !sdo));

  // R8: deselect turns the driver off
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !sdo_oe);

  // R9: no array traffic starts while deselected
  p_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    (!cs && !$past(cs)) |-> !arr_req);
endmodule

// File: tb/serial_read_out_test.sv
module serial_read_out_test;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int PW    = 6;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0;
  logic          sk_rise = 1'b0;
  logic          go_mem = 1'b0;
  logic          go_prot = 1'b0;
  logic [AW-1:0] go_addr = '0;
  logic [PW-1:0] prot_val = '0;
  logic          arr_req;
  logic [AW-1:0] arr_addr;
  logic          arr_valid = 1'b0;
  logic [DW-1:0] arr_data = '0;
  logic          sdo;
  logic          sdo_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int req_cnt = 0;
  bit done    = 1'b0;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    exp_q[$];
  string         tag_q[$];
  event          smp_ev;

  always #5 clk = ~clk;

  serial_read_out #(.DEPTH(DEPTH), .DW(DW), .PW(PW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .cs(cs), .sk_rise(sk_rise), .go_mem(go_mem),
    .go_prot(go_prot), .go_addr(go_addr), .prot_val(prot_val),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_valid(arr_valid),
    .arr_data(arr_data), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // array model: one-cycle read latency
  always @(posedge clk) begin
    arr_valid <= arr_req;
    if (arr_req) arr_data <= mem[arr_addr];
    if (arr_req) req_cnt <= req_cnt + 1;
  end

  // monitor: pops the scoreboard at each sample point
  always @(smp_ev) begin
    logic [1:0] e;
    string t;
    if (exp_q.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard empty: actual oe=%b sdo=%b expected an entry", sdo_oe, sdo);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if ({sdo_oe, sdo} !== e) begin
        n_fail++;
        $display("FAIL %s: actual oe=%b sdo=%b expected oe=%b sdo=%b", t, sdo_oe, sdo, e[1], e[0]);
      end
    end
  end

  task automatic push(input logic oe, input logic d, input string tag);
    exp_q.push_back({oe, d});
    tag_q.push_back(tag);
  endtask

  task automatic push_word(input logic [DW-1:0] w, input string tag);
    for (int i = DW - 1; i >= 0; i--) push(1'b1, w[i], tag);
  endtask

  task automatic sk_bit();
    @(negedge clk) sk_rise = 1'b1;
    @(negedge clk) sk_rise = 1'b0;
    -> smp_ev;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_mem(input logic [AW-1:0] a);
    @(negedge clk) begin go_mem = 1'b1; go_addr = a; end
    @(negedge clk) go_mem = 1'b0;
    -> smp_ev;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_prot();
    @(negedge clk) go_prot = 1'b1;
    @(negedge clk) go_prot = 1'b0;
    -> smp_ev;
    @(negedge clk);
  endtask

  task automatic drop_cs();
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
    -> smp_ev;
    @(negedge clk);
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h8421 ^ DW'(i * 16'h1357);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    push(1'b0, 1'b0, "R1");
    @(negedge clk) -> smp_ev;

    // single word read, R2 dummy then R3 bits
    @(negedge clk) cs = 1'b1;
    push(1'b1, 1'b0, "R2");
    start_mem(4'd3);
    push_word(mem[3], "R3");
    for (int i = 0; i < DW; i++) sk_bit();
    push(1'b0, 1'b0, "R8");
    drop_cs();

    // burst across the wrap: 14, 15, 0, 1
    @(negedge clk) begin cs = 1'b1; req_cnt = 0; end
    push(1'b1, 1'b0, "R2");
    start_mem(4'd14);
    push_word(mem[14], "R3");
    push_word(mem[15], "R4");
    push_word(mem[0], "R5");
    push_word(mem[1], "R4");
    for (int i = 0; i < 4 * DW; i++) sk_bit();
    check_int(req_cnt, 5, "R10");
    push(1'b0, 1'b0, "R8");
    drop_cs();

    // protect read, R6 bits then R7 trailing zeros
    prot_val = 6'b101101;
    @(negedge clk) cs = 1'b1;
    push(1'b1, 1'b0, "R2");
    start_prot();
    for (int i = PW - 1; i >= 0; i--) push(1'b1, prot_val[i], "R6");
    push(1'b1, 1'b0, "R7");
    push(1'b1, 1'b0, "R7");
    for (int i = 0; i < PW + 2; i++) sk_bit();
    push(1'b0, 1'b0, "R8");
    drop_cs();

    // R9: strobes while deselected do nothing
    req_cnt = 0;
    push(1'b0, 1'b0, "R9");
    start_mem(4'd5);
    push(1'b0, 1'b0, "R9");
    sk_bit();
    push(1'b0, 1'b0, "R9");
    start_prot();
    check_int(req_cnt, 0, "R9");

    // burst from 15 cut mid word, then a fresh read
    @(negedge clk) cs = 1'b1;
    push(1'b1, 1'b0, "R2");
    start_mem(4'd15);
    push_word(mem[15], "R3");
    for (int i = DW - 1; i >= DW - 5; i--) push(1'b1, mem[0][i], "R5");
    for (int i = 0; i < DW + 5; i++) sk_bit();
    push(1'b0, 1'b0, "R8");
    drop_cs();
    @(negedge clk) cs = 1'b1;
    push(1'b1, 1'b0, "R8");
    start_mem(4'd7);
    push_word(mem[7], "R3");
    for (int i = 0; i < DW; i++) sk_bit();
    push(1'b0, 1'b0, "R8");
    drop_cs();

    repeat (4) @(negedge clk);
    check_int(exp_q.size(), 0, "scoreboard drained");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule